// File: doc/BRIEF.md
# Word-Level Transaction Engine with Versioned Lock Records

This block runs hardware transactions over a small on-chip word store, shared by a fixed number of transaction contexts. Each data word has a companion record word. When the record is odd, it is a version number and the word may be read by anyone. When the record is even, it names the context that holds the word exclusively.

Reads are optimistic. The value comes straight from the store. It is accepted at once when its version is no newer than the timestamp the context captured at begin. Otherwise the engine checks every entry in the context's read set against the live records.

Writes are pessimistic and update in place. The engine validates the record, takes ownership of it, notes the record and its pre-acquire version in the write set, and saves the old word in an undo log. A commit publishes a fresh odd version on every owned record. An abort replays the undo log newest entry first, then puts the old versions back.

A client drives one request at a time over a valid/ready handshake. Each request carries a context number, an operation, a word address and write data. Each accepted request gets exactly one response pulse, with a status, an abort cause and read data. A WAIT status asks the client to retry the same request later.

Top module: `tmv_engine`

## Requirements
- R1: After reset, every record holds version 1, every data word is 0, the global timestamp is 1, no context is active, req_ready is 1 and rsp_valid is 0. An odd record is a version. An even record equal to {ctx,1'b0} means context ctx owns the word.
- R2: Opcodes are BEGIN=0, READ=1, WRITE=2, COMMIT=3, ABORT=4; statuses are OK=0, ABORT=1, WAIT=2. BEGIN on an idle context makes it active, captures the global timestamp as its start timestamp and answers OK. BEGIN on an active context answers OK and changes nothing.
- R3: A READ of a word whose record is a version no greater than the start timestamp answers OK with the stored word, and appends (address, version) to the context's read set; equality takes this fast path.
- R4: A READ or WRITE that finds a version newer than the start timestamp revalidates the whole read set. An entry passes if its record still equals the saved version or is owned by the same context. Any failing entry gives status ABORT with cause CONFLICT=1 and a rollback; if all pass, the operation proceeds.
- R5: A READ or WRITE of a word owned by another context answers WAIT and changes no word, record or set.
- R6: A WRITE to an unowned word takes ownership, logs the pre-acquire version and the old word, and stores the new word. A WRITE to a word the context already owns only logs the old word and stores the new one. A READ of an owned word by its owner answers OK with the latest written value.
- R7: COMMIT gives every record the context owns the version (global timestamp + 2). It then adds 2 to the global timestamp, empties the context's sets, makes the context idle and answers OK.
- R8: A rollback with n undo entries restores one entry per cycle, newest first. It then returns every owned record to its pre-acquire version and makes the context idle. req_ready stays 0 for n+1 cycles, and the ABORT response arrives n+2 cycles after the accepting edge.
- R9: A READ with a full read set, or a WRITE that needs a write-set or undo-log entry when that store is full, gives ABORT with cause CAPACITY=2 and a rollback.
- R10: ABORT on an active context gives cause USER=3 and a rollback. Any non-BEGIN request on an idle context, and opcodes 5 to 7, give ABORT with cause NOTX=4 and change nothing. Non-ABORT responses carry cause NONE=0.
- R11: A request is accepted on a clock edge where req_valid and req_ready are both 1. A request that does not roll back gets its single response in the cycle right after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine can accept a request (low during rollback) |
| req_ctx | input | $clog2(NCTX) | Requesting transaction context |
| req_op | input | 3 | Operation code |
| req_addr | input | $clog2(NWORDS) | Word address, also the record index |
| req_wdata | input | DW | Data for WRITE |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_status | output | 2 | OK, ABORT or WAIT |
| rsp_cause | output | 3 | Abort cause code |
| rsp_rdata | output | DW | Read data for an OK READ, else 0 |

## Verification
The bench builds the engine with four contexts, eight words, a read set of 3, a write set of 2 and an undo log of 3. With these sizes, each of the three capacity aborts takes only a few requests to reach.

An undo log of 3, filled by repeated writes to one word, makes reverse replay observable: a forward replay would leave a different value behind. Two contexts share one word across commits, so a stale read set meets a bumped version and exercises the conflict path. The same scenarios also cover the equal-version fast path and the wait-on-owner path.

// File: rtl/tmv_pkg.sv
// Shared codes for the transaction engine: operations, response status
// and abort causes. Assumes a 3-bit opcode field on the request side.
package tmv_pkg;
    typedef enum logic [2:0] {
        OP_BEGIN  = 3'd0,
        OP_READ   = 3'd1,
        OP_WRITE  = 3'd2,
        OP_COMMIT = 3'd3,
        OP_ABORT  = 3'd4
    } tm_op_e;

    typedef enum logic [1:0] {
        ST_OK    = 2'd0,
        ST_ABORT = 2'd1,
        ST_WAIT  = 2'd2
    } tm_status_e;

    typedef enum logic [2:0] {
        CZ_NONE     = 3'd0,
        CZ_CONFLICT = 3'd1,
        CZ_CAPACITY = 3'd2,
        CZ_USER     = 3'd3,
        CZ_NOTX     = 3'd4
    } tm_cause_e;
endpackage

// File: rtl/tmv_rset.sv
// Per-context read set: stores (record index, version seen) pairs and
// checks all live entries against the current records in parallel.
// Assumes NWORDS is a power of two and DEPTH >= 2.
module tmv_rset #(
    parameter int NWORDS = 8,
    parameter int RW     = 8,
    parameter int DEPTH  = 8,
    localparam int AW    = $clog2(NWORDS),
    localparam int PW    = $clog2(DEPTH),
    localparam int CNTW  = $clog2(DEPTH + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear,
    input  logic                         push,
    input  logic [AW-1:0]                push_idx,
    input  logic [RW-1:0]                push_ver,
    input  logic [NWORDS-1:0][RW-1:0]    recs,
    input  logic [RW-1:0]                own_rec,
    output logic                         full,
    output logic                         consistent
);
    logic [DEPTH-1:0][AW-1:0] idx_q;
    logic [DEPTH-1:0][RW-1:0] ver_q;
    logic [CNTW-1:0]          cnt_q;

    assign full = (cnt_q == CNTW'(DEPTH));

    // Append one pair per push; clear empties the set.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (push && !full) begin
            idx_q[PW'(cnt_q)] <= push_idx;
            ver_q[PW'(cnt_q)] <= push_ver;
            cnt_q             <= cnt_q + 1'b1;
        end
    end

    // Every live entry must still see its version, or be owned by this context.
    always_comb begin
        consistent = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            if (i < int'(cnt_q) && recs[idx_q[i]] != ver_q[i] && recs[idx_q[i]] != own_rec)
                consistent = 1'b0;
        end
    end
endmodule

// File: rtl/tmv_ulog.sv
// Per-context write set (record index, pre-acquire version) and undo log
// (address, old word). Entries are exposed so the engine can release
// records on commit and replay the log on rollback.
// Assumes both depths are at least 2.
module tmv_ulog #(
    parameter int NWORDS   = 8,
    parameter int DW       = 16,
    parameter int RW       = 8,
    parameter int WS_DEPTH = 4,
    parameter int UL_DEPTH = 8,
    localparam int AW      = $clog2(NWORDS),
    localparam int WSPW    = $clog2(WS_DEPTH),
    localparam int ULPW    = $clog2(UL_DEPTH),
    localparam int WSCW    = $clog2(WS_DEPTH + 1),
    localparam int ULCW    = $clog2(UL_DEPTH + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clear,
    input  logic                          ws_push,
    input  logic                          ul_push,
    input  logic [AW-1:0]                 addr,
    input  logic [RW-1:0]                 prever,
    input  logic [DW-1:0]                 old_word,
    output logic                          ws_full,
    output logic                          ul_full,
    output logic [WSCW-1:0]               ws_cnt,
    output logic [ULCW-1:0]               ul_cnt,
    output logic [WS_DEPTH-1:0][AW-1:0]   ws_idx,
    output logic [WS_DEPTH-1:0][RW-1:0]   ws_ver,
    output logic [UL_DEPTH-1:0][AW-1:0]   ul_addr,
    output logic [UL_DEPTH-1:0][DW-1:0]   ul_old
);
    assign ws_full = (ws_cnt == WSCW'(WS_DEPTH));
    assign ul_full = (ul_cnt == ULCW'(UL_DEPTH));

    // Write-set append on first acquisition of a record.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            ws_cnt <= '0;
        end else if (ws_push && !ws_full) begin
            ws_idx[WSPW'(ws_cnt)] <= addr;
            ws_ver[WSPW'(ws_cnt)] <= prever;
            ws_cnt                <= ws_cnt + 1'b1;
        end
    end

    // Undo-log append on every in-place store.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            ul_cnt <= '0;
        end else if (ul_push && !ul_full) begin
            ul_addr[ULPW'(ul_cnt)] <= addr;
            ul_old[ULPW'(ul_cnt)]  <= old_word;
            ul_cnt                 <= ul_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tmv_engine.sv
// Transaction engine top: word store, record array, global timestamp,
// per-context begin timestamps, request decode and the rollback walker.
// Assumes NWORDS is a power of two, NCTX >= 2, RW > $clog2(NCTX) + 1,
// all set depths >= 2. One request is decoded per cycle; rollback is
// sequential and blocks new requests.
module tmv_engine #(
    parameter int NCTX     = 4,
    parameter int NWORDS   = 8,
    parameter int DW       = 16,
    parameter int RW       = 8,
    parameter int RS_DEPTH = 8,
    parameter int WS_DEPTH = 4,
    parameter int UL_DEPTH = 8,
    localparam int CW      = $clog2(NCTX),
    localparam int AW      = $clog2(NWORDS),
    localparam int WSCW    = $clog2(WS_DEPTH + 1),
    localparam int ULCW    = $clog2(UL_DEPTH + 1),
    localparam int ULPW    = $clog2(UL_DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [CW-1:0] req_ctx,
    input  logic [2:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [1:0]    rsp_status,
    output logic [2:0]    rsp_cause,
    output logic [DW-1:0] rsp_rdata
);
    import tmv_pkg::*;

    function automatic logic [RW-1:0] own_id(input logic [CW-1:0] c);
        return RW'({c, 1'b0});
    endfunction

    logic [NWORDS-1:0][DW-1:0] mem_q;
    logic [NWORDS-1:0][RW-1:0] rec_q;
    logic [RW-1:0]             gts_q;
    logic [NCTX-1:0][RW-1:0]   ts_q;
    logic [NCTX-1:0]           active_q;
    logic                      rolling_q;
    logic [CW-1:0]             roll_ctx_q;
    logic [ULCW-1:0]           roll_idx_q;
    tm_cause_e                 roll_cause_q;

    logic [NCTX-1:0]                         rs_full, rs_cons, ws_full, ul_full;
    logic [NCTX-1:0]                         rs_push_v, ws_push_v, ul_push_v, clr_v;
    logic [NCTX-1:0][WSCW-1:0]               ws_cnt_a;
    logic [NCTX-1:0][ULCW-1:0]               ul_cnt_a;
    logic [NCTX-1:0][WS_DEPTH-1:0][AW-1:0]   ws_idx_a;
    logic [NCTX-1:0][WS_DEPTH-1:0][RW-1:0]   ws_ver_a;
    logic [NCTX-1:0][UL_DEPTH-1:0][AW-1:0]   ul_addr_a;
    logic [NCTX-1:0][UL_DEPTH-1:0][DW-1:0]   ul_old_a;

    logic          acc;
    logic [RW-1:0] cur_rec;
    logic          is_ver, mine, fast, valid_ok, roll_done;
    logic [ULPW-1:0] roll_ptr;
    tm_status_e    d_status;
    tm_cause_e     d_cause;
    logic [DW-1:0] d_rdata;
    logic d_roll, d_rs_push, d_ws_push, d_ul_push, d_mem_wr, d_acquire, d_commit, d_begin;

    assign req_ready = !rolling_q;
    assign acc       = req_valid && req_ready;
    assign cur_rec   = rec_q[req_addr];
    assign is_ver    = cur_rec[0];
    assign mine      = (cur_rec == own_id(req_ctx));
    assign fast      = is_ver && (cur_rec <= ts_q[req_ctx]);
    assign valid_ok  = fast || rs_cons[req_ctx];
    assign roll_done = rolling_q && (roll_idx_q == '0);
    assign roll_ptr  = ULPW'(roll_idx_q - 1'b1);

    // One read set and one write-set/undo-log pair per context.
    for (genvar g = 0; g < NCTX; g++) begin : g_ctx
        assign rs_push_v[g] = acc && d_rs_push && (req_ctx == CW'(g));
        assign ws_push_v[g] = acc && d_ws_push && (req_ctx == CW'(g));
        assign ul_push_v[g] = acc && d_ul_push && (req_ctx == CW'(g));
        assign clr_v[g]     = (acc && d_commit && req_ctx == CW'(g)) ||
                              (roll_done && roll_ctx_q == CW'(g));

        tmv_rset #(.NWORDS(NWORDS), .RW(RW), .DEPTH(RS_DEPTH)) u_rset (
            .clk(clk), .rst_n(rst_n), .clear(clr_v[g]), .push(rs_push_v[g]),
            .push_idx(req_addr), .push_ver(cur_rec), .recs(rec_q),
            .own_rec(own_id(CW'(g))), .full(rs_full[g]), .consistent(rs_cons[g])
        );

        tmv_ulog #(.NWORDS(NWORDS), .DW(DW), .RW(RW), .WS_DEPTH(WS_DEPTH),
                   .UL_DEPTH(UL_DEPTH)) u_ulog (
            .clk(clk), .rst_n(rst_n), .clear(clr_v[g]),
            .ws_push(ws_push_v[g]), .ul_push(ul_push_v[g]),
            .addr(req_addr), .prever(cur_rec), .old_word(mem_q[req_addr]),
            .ws_full(ws_full[g]), .ul_full(ul_full[g]),
            .ws_cnt(ws_cnt_a[g]), .ul_cnt(ul_cnt_a[g]),
            .ws_idx(ws_idx_a[g]), .ws_ver(ws_ver_a[g]),
            .ul_addr(ul_addr_a[g]), .ul_old(ul_old_a[g])
        );
    end

    // Decode the presented request into a response and a set of actions.
    always_comb begin
        d_status = ST_OK;  d_cause = CZ_NONE;  d_rdata = '0;
        d_roll = 1'b0;  d_rs_push = 1'b0;  d_ws_push = 1'b0;  d_ul_push = 1'b0;
        d_mem_wr = 1'b0;  d_acquire = 1'b0;  d_commit = 1'b0;  d_begin = 1'b0;
        if (req_op == OP_BEGIN) begin
            d_begin = !active_q[req_ctx];
        end else if (!active_q[req_ctx]) begin
            d_status = ST_ABORT;  d_cause = CZ_NOTX;
        end else begin
            case (req_op)
                OP_READ: begin
                    if (!is_ver && !mine)      d_status = ST_WAIT;
                    else if (mine)             d_rdata = mem_q[req_addr];
                    else if (!valid_ok)        begin d_roll = 1'b1; d_cause = CZ_CONFLICT; end
                    else if (rs_full[req_ctx]) begin d_roll = 1'b1; d_cause = CZ_CAPACITY; end
                    else begin d_rdata = mem_q[req_addr]; d_rs_push = 1'b1; end
                end
                OP_WRITE: begin
                    if (!is_ver && !mine)      d_status = ST_WAIT;
                    else if (mine) begin
                        if (ul_full[req_ctx])  begin d_roll = 1'b1; d_cause = CZ_CAPACITY; end
                        else begin d_ul_push = 1'b1; d_mem_wr = 1'b1; end
                    end
                    else if (!valid_ok)        begin d_roll = 1'b1; d_cause = CZ_CONFLICT; end
                    else if (ws_full[req_ctx] || ul_full[req_ctx]) begin
                        d_roll = 1'b1; d_cause = CZ_CAPACITY;
                    end else begin
                        d_acquire = 1'b1; d_ws_push = 1'b1; d_ul_push = 1'b1; d_mem_wr = 1'b1;
                    end
                end
                OP_COMMIT: d_commit = 1'b1;
                OP_ABORT:  begin d_roll = 1'b1; d_cause = CZ_USER; end
                default:   begin d_status = ST_ABORT; d_cause = CZ_NOTX; end
            endcase
        end
    end

    // Store, records, timestamps, rollback walker and response register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NWORDS; i++) begin
                mem_q[i] <= '0;
                rec_q[i] <= RW'(1);
            end
            gts_q <= RW'(1);  ts_q <= '0;  active_q <= '0;
            rolling_q <= 1'b0;  roll_ctx_q <= '0;  roll_idx_q <= '0;  roll_cause_q <= CZ_NONE;
            rsp_valid <= 1'b0;  rsp_status <= '0;  rsp_cause <= '0;  rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (rolling_q) begin
                if (roll_idx_q != '0) begin
                    mem_q[ul_addr_a[roll_ctx_q][roll_ptr]] <= ul_old_a[roll_ctx_q][roll_ptr];
                    roll_idx_q <= roll_idx_q - 1'b1;
                end else begin
                    for (int w = 0; w < WS_DEPTH; w++)
                        if (w < int'(ws_cnt_a[roll_ctx_q]))
                            rec_q[ws_idx_a[roll_ctx_q][w]] <= ws_ver_a[roll_ctx_q][w];
                    active_q[roll_ctx_q] <= 1'b0;
                    rolling_q  <= 1'b0;
                    rsp_valid  <= 1'b1;
                    rsp_status <= ST_ABORT;
                    rsp_cause  <= roll_cause_q;
                    rsp_rdata  <= '0;
                end
            end else if (acc) begin
                if (d_roll) begin
                    rolling_q    <= 1'b1;
                    roll_ctx_q   <= req_ctx;
                    roll_idx_q   <= ul_cnt_a[req_ctx];
                    roll_cause_q <= d_cause;
                end else begin
                    rsp_valid  <= 1'b1;
                    rsp_status <= d_status;
                    rsp_cause  <= d_cause;
                    rsp_rdata  <= d_rdata;
                end
                if (d_mem_wr)  mem_q[req_addr] <= req_wdata;
                if (d_acquire) rec_q[req_addr] <= own_id(req_ctx);
                if (d_begin) begin
                    active_q[req_ctx] <= 1'b1;
                    ts_q[req_ctx]     <= gts_q;
                end
                if (d_commit) begin
                    for (int w = 0; w < WS_DEPTH; w++)
                        if (w < int'(ws_cnt_a[req_ctx]))
                            rec_q[ws_idx_a[req_ctx][w]] <= gts_q + RW'(2);
                    gts_q <= gts_q + RW'(2);
                    active_q[req_ctx] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/tmv_engine_chk.sv
// Property checker for tmv_engine, attached by bind. Observes the
// response port, the rollback flag, the global timestamp and the store.
module tmv_engine_chk #(
    parameter int NWORDS = 8,
    parameter int DW     = 16,
    parameter int RW     = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      acc,
    input logic                      rolling,
    input logic                      rsp_valid,
    input logic [1:0]                rsp_status,
    input logic [2:0]                rsp_cause,
    input logic [RW-1:0]             gts,
    input logic [NWORDS-1:0][DW-1:0] mem_flat,
    input logic [NWORDS-1:0][RW-1:0] rec_flat
);
    // R8: no response leaves while a rollback is still walking the log.
    assert_no_rsp_in_roll_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rolling |-> !rsp_valid);

    // R11: every response follows an accepted request or a rollback.
    assert_rsp_has_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(acc) || $past(rolling)));

    // R7: the global timestamp only ever moves up by 2.
    assert_gts_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gts) |-> (gts == $past(gts) + RW'(2)));

    // R5: a WAIT answer leaves store and records untouched.
    assert_wait_no_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == 2'd2) |-> ($stable(mem_flat) && $stable(rec_flat)));

    // R10: cause is nonzero exactly on ABORT responses.
    assert_cause_matches_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ((rsp_status == 2'd1) == (rsp_cause != 3'd0)));
endmodule

bind tmv_engine tmv_engine_chk #(.NWORDS(NWORDS), .DW(DW), .RW(RW)) u_chk (
    .clk(clk), .rst_n(rst_n), .acc(acc), .rolling(rolling_q),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_cause(rsp_cause),
    .gts(gts_q), .mem_flat(mem_q), .rec_flat(rec_q)
);

// File: tb/sim_tmv_engine.sv
// Bench: a vector table of requests and expected responses walked in
// order, then directed tests for rollback timing and reset.
module sim_tmv_engine;
    import tmv_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_ctx = '0;
    logic [2:0]  req_op = '0;
    logic [2:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_status;
    logic [2:0]  rsp_cause;
    logic [15:0] rsp_rdata;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tmv_engine #(.NCTX(4), .NWORDS(8), .DW(16), .RW(8),
                 .RS_DEPTH(3), .WS_DEPTH(2), .UL_DEPTH(3)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_ctx(req_ctx), .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_cause(rsp_cause),
        .rsp_rdata(rsp_rdata)
    );

    typedef struct packed {
        logic [1:0]  c;
        logic [2:0]  op;
        logic [2:0]  a;
        logic [15:0] wd;
        logic [1:0]  st;
        logic [2:0]  cz;
        logic [15:0] rd;
        logic        chk;
        logic [3:0]  lat;
        logic [3:0]  r;
    } vec_t;

    localparam int NV = 39;
    localparam vec_t VEC [NV] = '{
        '{2'd0, OP_BEGIN,  3'd0, 16'h0,    ST_OK,    CZ_NONE,     16'h0,    1'b0, 4'd1, 4'd2},  // R2
        '{2'd1, OP_BEGIN,  3'd0, 16'h0,    ST_OK,    CZ_NONE,     16'h0,    1'b0, 4'd1, 4'd2},  // R2
        '{2'd0, OP_WRITE,  3'd2, 16'h1111, ST_OK,    CZ_NONE,     16'h0,    1'b0, 4'd1, 4'd6},  // R6
        '{2'd0, OP_READ,   3'd2, 16'h0,    ST_OK,    CZ_NONE,     16'h1111, 1'b1, 4'd1, 4'd6},  // R6 own read
        '{2'd1, OP_READ,   3'd2, 16'h0,    ST_WAIT,  CZ_NONE,     16'h0,    1'b0, 4'd1, 4'd5},  // R5
        '{2'd1, OP_WRITE,  3'd2, 16'hDEAD, ST_WAIT,  CZ_NONE,     16'h0,    1'b0, 4'd1, 4'd5},  // R5
        '{2'd1, OP_READ,   3'd3, 16'h0,    ST_OK,    CZ_NONE,     16'h0,    1'b1, 4'd1, 4'd3},  // R3
        '{2'd0, OP_WRITE,  3'd2, 16'h2222, ST_OK,    CZ_NONE,     16'h0,    1'b0, 4'd1, 4'd6},  // R6 rewrite
        '{2'd0, OP_COMMIT, 3'd0, 16'h0,    ST_OK,    CZ_NONE,     16'h0,    1'b0, 4'd1, 4'd7},  // R7
        '{2'd1, OP_READ,   3'd2, 16'h0,    ST_OK,    CZ_NONE,     16'h2222, 1'b1, 4'd1, 4'd4},  // R4 slow pass
        '{2'd0, OP_BEGIN,  3'd0, 16'h0,    ST_OK,    CZ_NONE,     16'h0,    1'b0, 4'd1, 4'd2},  // R2
        '{2'd0, OP_WRITE,  3'd3, 16'h0033, ST_OK,    CZ_NONE,     16'h0,    1'b0, 4'd1, 4'd6},  // R6
        '{2'd0, OP_COMMIT, 3'd0, 16'h0,    ST_OK,    CZ_NONE,     16'h0,    1'b0, 4'd1, 4'd7},  // R7
        '{2'd1, OP_READ,   3'd4, 16'h0,    ST_OK,    CZ_NONE,     16'h0,    1'b1, 4'd1, 4'd3},  // R3
        '{2'd1, OP_WRITE,  3'd3, 16'h0077, ST_ABORT, CZ_CONFLICT, 16'h0,    1'b0, 4'd2, 4'd4},  // R4 conflict
        '{2'd1, OP_READ,   3'd0, 16'h0,    ST_ABORT, CZ_NOTX,     16'h0,    1'b0, 4'd1, 4'd10}, // R10
        '{2'd0, OP_READ,   3'd3, 16'h0,    ST_ABORT, CZ_NOTX,     16'h0,    1'b0, 4'd1, 4'd7},  // R7 idle after commit
        '{2'd2, OP_BEGIN,  3'd0, 16'h0,    ST_OK,    CZ_NONE,     16'h0,    1'b0, 4'd1, 4'd2},  // R2
        '{2'd2, OP_READ,   3'd3, 16'h0,    ST_OK,    CZ_NONE,     16'h0033, 1'b1, 4'd1, 4'd3},  // R3 equal version
        '{2'd2, OP_READ,   3'd0, 16'h0,    ST_OK,    CZ_NONE,     16'h0,    1'b1, 4'd1, 4'd3},  // R3
        '{2'd2, OP_READ,   3'd1, 16'h0,    ST_OK,    CZ_NONE,     16'h0,    1'b1, 4'd1, 4'd3},  // R3
        '{2'd2, OP_READ,   3'd5, 16'h0,    ST_ABORT, CZ_CAPACITY, 16'h0,    1'b0, 4'd2, 4'd9},  // R9 read set
        '{2'd3, OP_BEGIN,  3'd0, 16'h0,    ST_OK,    CZ_NONE,     16'h0,    1'b0, 4'd1, 4'd2},  // R2
        '{2'd3, OP_WRITE,  3'd0, 16'h00A0, ST_OK,    CZ_NONE,     16'h0,    1'b0, 4'd1, 4'd6},  // R6
        '{2'd3, OP_WRITE,  3'd1, 16'h00A1, ST_OK,    CZ_NONE,     16'h0,    1'b0, 4'd1, 4'd6},  // R6
        '{2'd3, OP_WRITE,  3'd5, 16'h00A5, ST_ABORT, CZ_CAPACITY, 16'h0,    1'b0, 4'd4, 4'd9},  // R9 write set
        '{2'd0, OP_BEGIN,  3'd0, 16'h0,    ST_OK,    CZ_NONE,     16'h0,    1'b0, 4'd1, 4'd2},  // R2
        '{2'd0, OP_READ,   3'd0, 16'h0,    ST_OK,    CZ_NONE,     16'h0,    1'b1, 4'd1, 4'd8},  // R8 restored
        '{2'd0, OP_READ,   3'd1, 16'h0,    ST_OK,    CZ_NONE,     16'h0,    1'b1, 4'd1, 4'd8},  // R8 restored
        '{2'd0, OP_WRITE,  3'd6, 16'h0001, ST_OK,    CZ_NONE,     16'h0,    1'b0, 4'd1, 4'd6},  // R6
        '{2'd0, OP_WRITE,  3'd6, 16'h0002, ST_OK,    CZ_NONE,     16'h0,    1'b0, 4'd1, 4'd6},  // R6
        '{2'd0, OP_WRITE,  3'd6, 16'h0003, ST_OK,    CZ_NONE,     16'h0,    1'b0, 4'd1, 4'd6},  // R6
        '{2'd0, OP_WRITE,  3'd6, 16'h0004, ST_ABORT, CZ_CAPACITY, 16'h0,    1'b0, 4'd5, 4'd9},  // R9 undo log
        '{2'd1, OP_BEGIN,  3'd0, 16'h0,    ST_OK,    CZ_NONE,     16'h0,    1'b0, 4'd1, 4'd2},  // R2
        '{2'd1, OP_READ,   3'd6, 16'h0,    ST_OK,    CZ_NONE,     16'h0,    1'b1, 4'd1, 4'd8},  // R8 reverse replay
        '{2'd1, OP_WRITE,  3'd7, 16'h0077, ST_OK,    CZ_NONE,     16'h0,    1'b0, 4'd1, 4'd6},  // R6
        '{2'd1, OP_ABORT,  3'd0, 16'h0,    ST_ABORT, CZ_USER,     16'h0,    1'b0, 4'd3, 4'd10}, // R10 user
        '{2'd2, OP_BEGIN,  3'd0, 16'h0,    ST_OK,    CZ_NONE,     16'h0,    1'b0, 4'd1, 4'd2},  // R2
        '{2'd2, OP_READ,   3'd7, 16'h0,    ST_OK,    CZ_NONE,     16'h0,    1'b1, 4'd1, 4'd8}   // R8
    };

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Present one request, wait for acceptance, then for its response.
    task automatic issue(input logic [1:0] c, input logic [2:0] op, input logic [2:0] a,
                         input logic [15:0] wd, output logic [1:0] st,
                         output logic [2:0] cz, output logic [15:0] rd, output int lat);
        @(negedge clk);
        req_valid = 1'b1; req_ctx = c; req_op = op; req_addr = a; req_wdata = wd;
        while (!req_ready) @(negedge clk);
        lat = 0;
        do begin
            @(negedge clk);
            req_valid = 1'b0;
            lat++;
        end while (!rsp_valid && lat < 40);
        st = rsp_status; cz = rsp_cause; rd = rsp_rdata;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [1:0]  st;
        logic [2:0]  cz;
        logic [15:0] rd;
        int          lat;
        string       tag;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);

        for (int i = 0; i < NV; i++) begin
            tag = $sformatf("R%0d step %0d", VEC[i].r, i);
            issue(VEC[i].c, VEC[i].op, VEC[i].a, VEC[i].wd, st, cz, rd, lat);
            check(st == VEC[i].st, tag, "status", st, VEC[i].st);
            check(cz == VEC[i].cz, tag, "cause", cz, VEC[i].cz);
            if (VEC[i].chk) check(rd == VEC[i].rd, tag, "rdata", rd, VEC[i].rd);
            // R11: one-cycle answer unless a rollback runs (R8)
            check(lat == int'(VEC[i].lat), tag, "latency", lat, VEC[i].lat);
        end

        // R8: ready held low for n+1 cycles during a two-entry rollback
        issue(2'd3, OP_BEGIN, 3'd0, 16'h0, st, cz, rd, lat);
        issue(2'd3, OP_WRITE, 3'd4, 16'h0044, st, cz, rd, lat);
        issue(2'd3, OP_WRITE, 3'd5, 16'h0055, st, cz, rd, lat);
        check(st == ST_OK, "R6", "second acquire", st, ST_OK);
        @(negedge clk);
        req_valid = 1'b1; req_ctx = 2'd3; req_op = OP_ABORT;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 3; k++) begin
            check(req_ready == 1'b0, "R8", "ready during rollback", req_ready, 0);
            check(rsp_valid == 1'b0, "R8", "no response during rollback", rsp_valid, 0);
            if (k < 2) @(negedge clk);
        end
        @(negedge clk);
        check(rsp_valid == 1'b1, "R8", "rollback response", rsp_valid, 1);
        check(rsp_cause == CZ_USER, "R10", "user cause", rsp_cause, CZ_USER);
        check(req_ready == 1'b1, "R8", "ready after rollback", req_ready, 1);
        issue(2'd0, OP_BEGIN, 3'd0, 16'h0, st, cz, rd, lat);
        issue(2'd0, OP_READ, 3'd4, 16'h0, st, cz, rd, lat);
        check(st == ST_OK && rd == 16'h0, "R8", "word 4 restored", rd, 0);
        issue(2'd0, OP_READ, 3'd5, 16'h0, st, cz, rd, lat);
        check(st == ST_OK && rd == 16'h0, "R8", "word 5 restored", rd, 0);
        // R10: unknown opcode is answered ABORT/NOTX
        issue(2'd0, 3'd6, 3'd0, 16'h0, st, cz, rd, lat);
        check(cz == CZ_NOTX, "R10", "unknown opcode cause", cz, CZ_NOTX);

        // R1: mid-run reset clears contexts and the store
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && rsp_valid == 1'b0, "R1", "ports after reset",
              {req_ready, rsp_valid}, 2'b10);
        issue(2'd0, OP_READ, 3'd0, 16'h0, st, cz, rd, lat);
        check(cz == CZ_NOTX, "R1", "context idle after reset", cz, CZ_NOTX);
        issue(2'd0, OP_BEGIN, 3'd0, 16'h0, st, cz, rd, lat);
        issue(2'd0, OP_READ, 3'd3, 16'h0, st, cz, rd, lat);
        check(st == ST_OK && rd == 16'h0, "R1", "word cleared by reset", rd, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule